// File: doc/BRIEF.md
# Combinational ALU with Signed Less-Than Compare

This block is a purely combinational arithmetic-logic unit for a datapath. Two operands of `WIDTH` bits (32 by default) and a 3-bit operation code go in; a result word and a flag that reports an all-zero result come out in the same cycle. It provides bitwise AND, bitwise OR, addition, subtraction and a signed less-than compare that yields 0 or 1 in the result word.

The most significant code bit does two jobs. It inverts operand B and it supplies the carry-in, so one adder computes both A+B and A+~B+1. The two low code bits then choose the AND, OR, sum or compare path.

The compare reads the sign bit of the raw difference. It does not correct that bit for overflow, so a large negative A minus a large positive B can report "not less". The adder carry-out is dropped, and the block has no clock, no state and no overflow output. A parameter selects the adder form: an explicit per-bit ripple chain or a single behavioural sum.

Top module: `alu_slt_core`

## Requirements
- R1: Code 3'b000 drives `res_o` with the bitwise AND of `a_i` and `b_i`.
- R2: Code 3'b001 drives `res_o` with the bitwise OR of `a_i` and `b_i`.
- R3: Code 3'b010 drives `res_o` with `a_i + b_i` modulo 2^WIDTH, and the carry-out is dropped. For example, FFFF_FFFF + 0000_0001 gives 0000_0000.
- R4: Code 3'b110 drives `res_o` with `a_i - b_i` modulo 2^WIDTH, formed as `a_i + ~b_i + 1`. For example, 0000_0000 − 0000_0001 gives FFFF_FFFF.
- R5: Code 3'b111 drives bit 0 of `res_o` with bit WIDTH-1 of the modular difference `a_i - b_i`, with no overflow correction. All other bits of `res_o` are 0. For example, A=D8A3_B8D3 and B=63B9_D6F2 give 0.
- R6: Codes 3'b011, 3'b100 and 3'b101 drive `res_o` to all zeros.
- R7: `zero_o` is 1 exactly when every bit of `res_o` is 0, for every code, including a compare result of 0.
- R8: The outputs depend only on the present inputs. A new input set is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 3 | Operation code: bit 2 inverts B and sets carry-in; bits 1:0 select the path |
| res_o | output | WIDTH | Selected result |
| zero_o | output | 1 | High when `res_o` is all zeros |

## Verification
The bench builds the block with `WIDTH` = 32 and the ripple adder form (`ADDER_RIPPLE` = 1). That exercises the full 32-stage carry chain and makes the 32-bit boundary vectors reachable: all-ones plus one wrapping to zero, zero minus one, and the overflowing negative-minus-positive compare. A pseudo-random sweep then covers all eight operation codes, including the three unused ones, and checks the zero flag on each item.

// File: rtl/alu_slt_pkg.sv
package alu_slt_pkg;

   typedef enum logic [2:0] {
      OPC_AND  = 3'b000,
      OPC_OR   = 3'b001,
      OPC_ADD  = 3'b010,
      OPC_SUB  = 3'b110,
      OPC_SLT  = 3'b111
   } alu_opc_e;

   // Bit 2 of the code inverts B and feeds the carry-in.
   localparam int unsigned NEG_BIT = 2;

   // Low two bits select the path.
   typedef enum logic [1:0] {
      PATH_AND = 2'b00,
      PATH_OR  = 2'b01,
      PATH_SUM = 2'b10,
      PATH_LT  = 2'b11
   } alu_path_e;

endpackage

// File: rtl/alu_slt_logic.sv
module alu_slt_logic #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign and_o[i] = a_i[i] & b_i[i];
      assign or_o[i]  = a_i[i] | b_i[i];
   end

endmodule

// File: rtl/alu_slt_adder.sv
module alu_slt_adder #(
   parameter int unsigned WIDTH  = 32,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_slt_adder: WIDTH must be at least 2");
   end

   if (RIPPLE) begin : g_ripple
      // carry[i] enters bit i; the carry out of the top bit is never formed
      logic [WIDTH-1:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         assign sum_o[i] = a_i[i] ^ b_i[i] ^ carry[i];
         if (i < WIDTH - 1) begin : g_cy
            assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
         end
      end
   end else begin : g_flat
      logic [WIDTH-1:0] cin_ext;
      assign cin_ext = {{(WIDTH-1){1'b0}}, cin_i};
      assign sum_o   = a_i + b_i + cin_ext;
   end

endmodule

// File: rtl/alu_slt_zero.sv
module alu_slt_zero #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] val_i,
   output logic             zero_o
);

   logic [WIDTH-1:0] any_set;

   assign any_set[0] = val_i[0];
   for (genvar i = 1; i < WIDTH; i++) begin : g_or
      assign any_set[i] = any_set[i-1] | val_i[i];
   end

   assign zero_o = ~any_set[WIDTH-1];

endmodule

// File: rtl/alu_slt_core.sv
module alu_slt_core
   import alu_slt_pkg::*;
#(
   parameter int unsigned WIDTH        = 32,
   parameter bit          ADDER_RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [2:0]       op_i,
   output logic [WIDTH-1:0] res_o,
   output logic             zero_o
);

   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_slt_core: WIDTH must be at least 2");
   end

   logic             negate;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] and_v;
   logic [WIDTH-1:0] or_v;
   logic [WIDTH-1:0] sum_v;
   logic [WIDTH-1:0] lt_v;

   assign negate = op_i[NEG_BIT];
   assign b_eff  = negate ? ~b_i : b_i;

   alu_slt_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i   (a_i),
      .b_i   (b_i),
      .and_o (and_v),
      .or_o  (or_v)
   );

   alu_slt_adder #(.WIDTH(WIDTH), .RIPPLE(ADDER_RIPPLE)) u_adder (
      .a_i   (a_i),
      .b_i   (b_eff),
      .cin_i (negate),
      .sum_o (sum_v)
   );

   // Raw sign of A-B, no overflow fix-up
   assign lt_v = {{(WIDTH-1){1'b0}}, sum_v[MSB]};

   always_comb begin
      unique case (op_i)
         OPC_AND: res_o = and_v;
         OPC_OR:  res_o = or_v;
         OPC_ADD: res_o = sum_v;
         OPC_SUB: res_o = sum_v;
         OPC_SLT: res_o = lt_v;
         default: res_o = '0;
      endcase
   end

   alu_slt_zero #(.WIDTH(WIDTH)) u_zero (
      .val_i  (res_o),
      .zero_o (zero_o)
   );

endmodule

// File: rtl/alu_slt_chk.sv
module alu_slt_chk #(
   parameter int unsigned WIDTH = 32
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [2:0]       op_i,
   input logic [WIDTH-1:0] res_o,
   input logic             zero_o
);

   always_comb begin
      if (!$isunknown({a_i, b_i, op_i, res_o, zero_o})) begin
         // R7
         zero_flag_chk: assert (zero_o == (res_o == '0))
            else $error("zero flag disagrees with result");
         // R1
         and_subset_chk: assert (op_i != 3'b000 || ((res_o & ~a_i) == '0 && (res_o & ~b_i) == '0 && ((a_i & b_i) & ~res_o) == '0))
            else $error("AND result wrong");
         // R2
         or_cover_chk: assert (op_i != 3'b001 || ((res_o & a_i) == a_i && (res_o & b_i) == b_i && (res_o & ~(a_i | b_i)) == '0))
            else $error("OR result wrong");
         // R3
         add_inverse_chk: assert (op_i != 3'b010 || (res_o - b_i) == a_i)
            else $error("sum does not invert");
         // R4
         sub_inverse_chk: assert (op_i != 3'b110 || (res_o + b_i) == a_i)
            else $error("difference does not invert");
         // R5
         slt_upper_clear_chk: assert (op_i != 3'b111 || res_o[WIDTH-1:1] == '0)
            else $error("compare result has upper bits set");
         // R6
         unused_code_chk: assert (!(op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) || res_o == '0)
            else $error("unused code gave non-zero result");
      end
   end

endmodule

bind alu_slt_core alu_slt_chk #(.WIDTH(WIDTH)) u_alu_slt_chk (
   .a_i    (a_i),
   .b_i    (b_i),
   .op_i   (op_i),
   .res_o  (res_o),
   .zero_o (zero_o)
);

// File: tb/alu_slt_core_bench.sv
module alu_slt_core_bench;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned W          = 32;
   localparam int unsigned WATCHDOG   = 20000;

   typedef struct {
      logic [W-1:0] res;
      logic         zero;
      string        req;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [2:0]   op = 3'b000;
   logic [W-1:0] res;
   logic         zero;

   int n_cmp  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_slt_core #(.WIDTH(W), .ADDER_RIPPLE(1'b1)) u_alu_slt_core (
      .a_i    (a),
      .b_i    (b),
      .op_i   (op),
      .res_o  (res),
      .zero_o (zero)
   );

   // Reference model written from the requirements
   function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] c);
      logic [W-1:0] d;
      d = x - y;
      case (c)
         3'b000: return x & y;
         3'b001: return x | y;
         3'b010: return x + y;
         3'b110: return d;
         3'b111: return {{(W-1){1'b0}}, d[W-1]};
         default: return '0;
      endcase
   endfunction

   function automatic string tag(input logic [2:0] c);
      case (c)
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010: return "R3";
         3'b110: return "R4";
         3'b111: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] c);
      exp_t e;
      @(negedge clk);
      a = x; b = y; op = c;
      e.res  = model(x, y, c);
      e.zero = (e.res == '0);
      e.req  = tag(c);
      sb.push_back(e);
   endtask

   task automatic drive_exp(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] c,
                            input logic [W-1:0] want, input string r);
      exp_t e;
      @(negedge clk);
      a = x; b = y; op = c;
      e.res = want; e.zero = (want == '0); e.req = r;
      sb.push_back(e);
   endtask

   // Monitor: outputs settle combinationally (R8), compared at the next edge
   always @(posedge clk) begin
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_cmp++;
         if (res !== e.res) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h op=%b res actual=%h expected=%h", e.req, a, b, op, res, e.res);
         end
         n_cmp++;
         if (zero !== e.zero) begin
            n_bad++;
            $display("FAIL R7 a=%h b=%h op=%b zero actual=%b expected=%b", a, b, op, zero, e.zero);
         end
      end
   end

   initial begin : watchdog
      for (int i = 0; i < WATCHDOG; i++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [W-1:0] s;
      repeat (3) @(posedge clk);
      // Reset state, inputs at zero: R8 and R7
      #1;
      n_cmp++;
      if (res !== '0 || zero !== 1'b1) begin
         n_bad++;
         $display("FAIL R8 reset-state res/zero actual=%h/%b expected=%h/1", res, zero, {W{1'b0}});
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1 AND
      drive_exp(32'h0F0F_0F0F, 32'hF0F0_F0F0, 3'b000, 32'h0000_0000, "R1");
      drive_exp(32'hFFFF_FFFF, 32'hFFFF_0000, 3'b000, 32'hFFFF_0000, "R1");
      drive_exp(32'hD8A3_B8D3, 32'h63B9_D6F2, 3'b000, 32'h40A1_90D2, "R1");
      // R2 OR
      drive_exp(32'h0F0F_0F0F, 32'hF0F0_F0F0, 3'b001, 32'hFFFF_FFFF, "R2");
      drive_exp(32'h0000_0000, 32'h0000_0000, 3'b001, 32'h0000_0000, "R2");
      drive_exp(32'hD8A3_B8D3, 32'h63B9_D6F2, 3'b001, 32'hFBBB_FEF3, "R2");
      // R3 add with wrap
      drive_exp(32'hFFFF_FFFF, 32'h0000_0001, 3'b010, 32'h0000_0000, "R3");
      drive_exp(32'h4FFF_FFFF, 32'h0000_0001, 3'b010, 32'h5000_0000, "R3");
      drive_exp(32'hD8A3_B8D3, 32'h63B9_D6F2, 3'b010, 32'h3C5D_8FC5, "R3");
      // R4 subtract
      drive_exp(32'h0000_0000, 32'h0000_0001, 3'b110, 32'hFFFF_FFFF, "R4");
      drive_exp(32'h0000_0001, 32'hD000_0000, 3'b110, 32'h3000_0001, "R4");
      drive_exp(32'hD8A3_B8D3, 32'h63B9_D6F2, 3'b110, 32'h74E9_E1E1, "R4");
      // R5 compare, incl. overflowing case giving 0
      drive_exp(32'h0000_0000, 32'h0000_0001, 3'b111, 32'h0000_0001, "R5");
      drive_exp(32'h0000_0001, 32'h0000_0000, 3'b111, 32'h0000_0000, "R5");
      drive_exp(32'hFFFF_FFFF, 32'h0000_0001, 3'b111, 32'h0000_0001, "R5");
      drive_exp(32'hD8A3_B8D3, 32'h63B9_D6F2, 3'b111, 32'h0000_0000, "R5");
      drive_exp(32'h1234_5678, 32'h1234_5678, 3'b111, 32'h0000_0000, "R5");
      // R6 unused codes
      drive_exp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, 32'h0000_0000, "R6");
      drive_exp(32'hFFFF_FFFF, 32'h0000_0000, 3'b100, 32'h0000_0000, "R6");
      drive_exp(32'h0000_0000, 32'hFFFF_FFFF, 3'b101, 32'h0000_0000, "R6");

      // Pseudo-random sweep over every code (R1..R7)
      s = 32'hACE1_2468;
      for (int i = 0; i < 200; i++) begin
         logic [W-1:0] x;
         logic [W-1:0] y;
         s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
         x = s;
         s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
         y = (i % 5 == 0) ? x : s;
         drive(x, y, 3'(i % 8));
      end

      @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule